// File: doc/BRIEF.md
# Power-Good Supervisor and Reset Sequencer

This block watches three supply rails and turns their state into two delayed power-good levels and a staged release of two active-low resets. Rail voltages reach it as millivolt codes from an external converter. Each rail keeps a stored good/bad state with separate rising and falling thresholds, so the state has hysteresis. Group A has one rail. Group B has a 5 V rail and a 3.3 V rail. A group's rails are checked only while that group's enable inputs are high.

Every delay counts a half-millisecond tick. A prescaler derives this tick from the `CLK_HZ` parameter, so a bench can shorten all delays by giving a small clock rate. The group B delay is picked when its count starts. It is long if group A power-good is high at that moment and short otherwise. Once group B power-good rises, the PCI reset is released, and then the CPU reset. The outputs are plain levels that an open-drain pad would drive.

The rail samples arrive as a valid/ready stream. `rail_ready` is always high, so the block never applies back-pressure. A sample is consumed on each cycle where `rail_valid` is high. The three codes in one beat are taken together, and nothing happens on cycles where `rail_valid` is low.

Top module: `pwr_seq_top`

## Requirements
- R1: The group A rail becomes good when a sample is strictly above 2943 mV. A code of exactly 2943 does not make it good. `pg_a` rises 350 ms (700 ticks) after the rail became good, within one tick.
- R2: A sample from 2793 to 2943 mV inclusive leaves the stored rail state unchanged. A sample strictly below 2793 makes the rail bad. Every stored rail state is bad after reset.
- R3: When the group A rail goes bad, `pg_a` falls on the next cycle and any delay in progress is cancelled. A later good sample restarts the full delay.
- R4: While `en_a` is low, the group A rail state is held bad and `pg_a` is low. Raising `en_a` again does not restore the old state; a new good sample is needed.
- R5: Group B is monitored only while both `en_b5` and `en_b3` are high. If either is low, both B rail states are held bad and `pg_b` is low.
- R6: The 5 V rail is good strictly above 4461 mV and bad strictly below 4311 mV. The 3.3 V rail uses the group A thresholds. Group B counts as good only while both of its rails are good.
- R7: A group B rail that is bad is acted on only after it has stayed bad for 47.5 ms (95 ticks). A dip that clears sooner has no effect on `pg_b`. A good rail is taken at once.
- R8: The `pg_b` delay is 445 ms (890 ticks) if `pg_a` is high when group B becomes good, and 100 ms (200 ticks) if `pg_a` is low. The length is fixed when the count starts, and later changes of `pg_a` do not alter it.
- R9: `pci_rst_n` rises exactly 2 ticks (1 ms) after `pg_b` rises. `cpu_rst_n` rises exactly 2 ticks after `pci_rst_n`. Both are low on the cycle after `pg_b` is low.
- R10: After reset all four outputs are low and `rail_ready` is high. Rail codes presented while `rail_valid` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| en_a | input | 1 | Group A monitoring enable |
| en_b5 | input | 1 | Group B enable, 5 V rail |
| en_b3 | input | 1 | Group B enable, 3.3 V rail |
| rail_valid | input | 1 | Rail sample beat valid |
| rail_ready | output | 1 | Sample accepted; always high |
| rail_a_mv | input | MV_W | Group A rail code in mV |
| rail_b5_mv | input | MV_W | Group B 5 V rail code in mV |
| rail_b3_mv | input | MV_W | Group B 3.3 V rail code in mV |
| pg_a | output | 1 | Group A delayed power-good |
| pg_b | output | 1 | Group B delayed power-good |
| pci_rst_n | output | 1 | PCI reset, active low |
| cpu_rst_n | output | 1 | CPU reset, active low |

## Verification
The bench drives codes exactly on each threshold. A design that used greater-or-equal would raise power-good there, and one without hysteresis would drop it on a code between the thresholds. It starts a long group B delay and then drops group A partway through. A design that chose the delay length continuously would release `pg_b` after 100 ms instead of 445 ms. Short dips on a B rail are checked to leave `pg_b` high, and longer ones to clear it only after 47.5 ms. The bench also measures the reset chain to the cycle and re-raises an enable without a new sample, which exposes a design that retains rail state while disabled.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  // All delays are counted in half-millisecond ticks.
  localparam int unsigned TICK_HZ = 2000;

  typedef enum logic {
    RAIL_BAD  = 1'b0,
    RAIL_GOOD = 1'b1
  } rail_st_e;

  function automatic int unsigned cnt_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned TICK_HZ = 2000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DIV   = (CLK_HZ / TICK_HZ < 2) ? 2 : CLK_HZ / TICK_HZ;
  localparam int unsigned DIV_W = $clog2(DIV);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else if (div_q == DIV_W'(DIV - 1)) begin
      div_q <= '0;
      tick  <= 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_rail_hyst.sv
module pwr_rail_hyst
  import pwr_seq_pkg::*;
#(
  parameter int unsigned MV_W    = 13,
  parameter int unsigned RISE_MV = 2943,
  parameter int unsigned FALL_MV = 2793
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            fire,
  input  logic [MV_W-1:0] mv,
  output logic            good
);
  rail_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      st_q <= RAIL_BAD;
    end else if (fire) begin
      if (mv > MV_W'(RISE_MV))      st_q <= RAIL_GOOD;
      else if (mv < MV_W'(FALL_MV)) st_q <= RAIL_BAD;
    end
  end

  assign good = (st_q == RAIL_GOOD);
endmodule

// File: rtl/pwr_bad_filter.sv
module pwr_bad_filter
  import pwr_seq_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  input  logic raw_good,
  output logic good
);
  localparam int unsigned CW = cnt_bits(HOLD_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      good  <= 1'b0;
      cnt_q <= '0;
    end else if (raw_good) begin
      good  <= 1'b1;
      cnt_q <= '0;
    end else if (good && tick) begin
      if (cnt_q == CW'(HOLD_TICKS - 1)) begin
        good  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_pg_delay.sv
module pwr_pg_delay
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 200,
  parameter int unsigned LONG_TICKS  = 890
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic tick,
  input  logic use_long,
  output logic pg
);
  localparam int unsigned MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int unsigned CW   = cnt_bits(MAXT);

  logic          run_q;
  logic [CW-1:0] tgt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !cond) begin
      run_q <= 1'b0;
      tgt_q <= '0;
      cnt_q <= '0;
      pg    <= 1'b0;
    end else if (!run_q) begin
      // Length is latched once, when the count starts.
      run_q <= 1'b1;
      tgt_q <= use_long ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);
      cnt_q <= '0;
    end else if (!pg && tick) begin
      if (cnt_q == tgt_q - 1'b1) pg <= 1'b1;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_rst_chain.sv
module pwr_rst_chain
  import pwr_seq_pkg::*;
#(
  parameter int unsigned PCI_TICKS = 2,
  parameter int unsigned CPU_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg,
  input  logic tick,
  output logic pci_rst_n,
  output logic cpu_rst_n
);
  localparam int unsigned MAXT = (PCI_TICKS > CPU_TICKS) ? PCI_TICKS : CPU_TICKS;
  localparam int unsigned CW   = cnt_bits(MAXT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !pg) begin
      pci_rst_n <= 1'b0;
      cpu_rst_n <= 1'b0;
      cnt_q     <= '0;
    end else if (tick) begin
      if (!pci_rst_n) begin
        if (cnt_q == CW'(PCI_TICKS - 1)) begin
          pci_rst_n <= 1'b1;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (!cpu_rst_n) begin
        if (cnt_q == CW'(CPU_TICKS - 1)) cpu_rst_n <= 1'b1;
        else                             cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 250_000_000,
  parameter int unsigned MV_W        = 13,
  parameter int unsigned A_RISE_MV   = 2943,
  parameter int unsigned A_FALL_MV   = 2793,
  parameter int unsigned B5_RISE_MV  = 4461,
  parameter int unsigned B5_FALL_MV  = 4311,
  parameter int unsigned B3_RISE_MV  = 2943,
  parameter int unsigned B3_FALL_MV  = 2793,
  parameter int unsigned A_DLY_T     = 700,
  parameter int unsigned B_SHORT_T   = 200,
  parameter int unsigned B_LONG_T    = 890,
  parameter int unsigned B_HOLD_T    = 95,
  parameter int unsigned PCI_T       = 2,
  parameter int unsigned CPU_T       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_a,
  input  logic            en_b5,
  input  logic            en_b3,
  input  logic            rail_valid,
  output logic            rail_ready,
  input  logic [MV_W-1:0] rail_a_mv,
  input  logic [MV_W-1:0] rail_b5_mv,
  input  logic [MV_W-1:0] rail_b3_mv,
  output logic            pg_a,
  output logic            pg_b,
  output logic            pci_rst_n,
  output logic            cpu_rst_n
);
  localparam int unsigned NB = 2;

  logic            tick;
  logic            fire;
  logic            a_good;
  logic            b_arm;
  logic [MV_W-1:0] b_mv [NB];
  logic [NB-1:0]   b_raw;
  logic [NB-1:0]   b_good;

  assign rail_ready = 1'b1;
  assign fire       = rail_valid & rail_ready;
  assign b_arm      = en_b5 & en_b3;
  assign b_mv[0]    = rail_b5_mv;
  assign b_mv[1]    = rail_b3_mv;

  pwr_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pwr_rail_hyst #(.MV_W(MV_W), .RISE_MV(A_RISE_MV), .FALL_MV(A_FALL_MV)) u_a_rail (
    .clk(clk), .rst_n(rst_n), .arm(en_a), .fire(fire), .mv(rail_a_mv), .good(a_good)
  );

  pwr_pg_delay #(.SHORT_TICKS(A_DLY_T), .LONG_TICKS(A_DLY_T)) u_a_dly (
    .clk(clk), .rst_n(rst_n), .cond(a_good & en_a), .tick(tick),
    .use_long(1'b0), .pg(pg_a)
  );

  for (genvar gi = 0; gi < NB; gi++) begin : g_brail
    localparam int unsigned RISE = (gi == 0) ? B5_RISE_MV : B3_RISE_MV;
    localparam int unsigned FALL = (gi == 0) ? B5_FALL_MV : B3_FALL_MV;

    pwr_rail_hyst #(.MV_W(MV_W), .RISE_MV(RISE), .FALL_MV(FALL)) u_hyst (
      .clk(clk), .rst_n(rst_n), .arm(b_arm), .fire(fire), .mv(b_mv[gi]), .good(b_raw[gi])
    );

    pwr_bad_filter #(.HOLD_TICKS(B_HOLD_T)) u_filt (
      .clk(clk), .rst_n(rst_n), .arm(b_arm), .tick(tick),
      .raw_good(b_raw[gi]), .good(b_good[gi])
    );
  end

  pwr_pg_delay #(.SHORT_TICKS(B_SHORT_T), .LONG_TICKS(B_LONG_T)) u_b_dly (
    .clk(clk), .rst_n(rst_n), .cond((&b_good) & b_arm), .tick(tick),
    .use_long(pg_a), .pg(pg_b)
  );

  pwr_rst_chain #(.PCI_TICKS(PCI_T), .CPU_TICKS(CPU_T)) u_rst (
    .clk(clk), .rst_n(rst_n), .pg(pg_b), .tick(tick),
    .pci_rst_n(pci_rst_n), .cpu_rst_n(cpu_rst_n)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en_a,
  input logic en_b5,
  input logic en_b3,
  input logic pg_a,
  input logic pg_b,
  input logic pci_rst_n,
  input logic cpu_rst_n
);
  assert_pga_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |=> !pg_a);

  assert_pgb_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_b5 && en_b3) |=> !pg_b);

  assert_pgb_rise_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_b) |-> $past(en_b5 && en_b3));

  assert_rst_follow_pgb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_b |=> (!pci_rst_n && !cpu_rst_n));

  assert_cpu_after_pci_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |-> pci_rst_n);

  assert_pci_rise_pg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_rst_n) |-> (pg_b && $past(pg_b)));
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b5(en_b5), .en_b3(en_b3),
  .pg_a(pg_a), .pg_b(pg_b), .pci_rst_n(pci_rst_n), .cpu_rst_n(cpu_rst_n)
);

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;
  localparam int unsigned MV_W = 13;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_a = 1'b0, en_b5 = 1'b0, en_b3 = 1'b0, rail_valid = 1'b0;
  logic [MV_W-1:0] rail_a_mv = '0, rail_b5_mv = '0, rail_b3_mv = '0;
  logic rail_ready, pg_a, pg_b, pci_rst_n, cpu_rst_n;

  always #2 clk = ~clk;

  pwr_seq_top #(.CLK_HZ(8000), .MV_W(MV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b5(en_b5), .en_b3(en_b3),
    .rail_valid(rail_valid), .rail_ready(rail_ready),
    .rail_a_mv(rail_a_mv), .rail_b5_mv(rail_b5_mv), .rail_b3_mv(rail_b3_mv),
    .pg_a(pg_a), .pg_b(pg_b), .pci_rst_n(pci_rst_n), .cpu_rst_n(cpu_rst_n)
  );

  typedef struct {
    int unsigned cyc;
    int          sig;
    logic        val;
    string       req;
  } exp_t;

  exp_t q[$];
  int unsigned cyc = 0;
  int n_run = 0, n_fail = 0;
  int unsigned pgb_rise = 0, pci_rise = 0, cpu_rise = 0;
  logic pgb_d = 1'b0, pci_d = 1'b0, cpu_d = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sig_val(input int s);
    case (s)
      0: return pg_a;
      1: return pg_b;
      2: return pci_rst_n;
      default: return cpu_rst_n;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops due items and compares, and records output rise cycles.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      check(sig_val(q[0].sig) === q[0].val, q[0].req, int'(sig_val(q[0].sig)), int'(q[0].val));
      void'(q.pop_front());
    end
    if (pg_b && !pgb_d) pgb_rise = cyc;
    if (pci_rst_n && !pci_d) pci_rise = cyc;
    if (cpu_rst_n && !cpu_d) cpu_rise = cyc;
    pgb_d = pg_b; pci_d = pci_rst_n; cpu_d = cpu_rst_n;
  end

  task automatic expect_at(input int d, input int s, input logic v, input string r);
    exp_t e;
    e.cyc = cyc + d; e.sig = s; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic sample(input int a, input int b5, input int b3, input logic vld);
    @(negedge clk);
    rail_a_mv = MV_W'(a); rail_b5_mv = MV_W'(b5); rail_b3_mv = MV_W'(b3);
    rail_valid = vld;
    @(negedge clk);
    rail_valid = 1'b0;
  endtask

  // Window for an N-tick delay measured from the sample call.
  task automatic expect_rise(input int s, input int n, input string r);
    expect_at((n - 1) * DIV - 2, s, 1'b0, r);
    expect_at((n + 1) * DIV + 4, s, 1'b1, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(pg_a === 1'b0 && pg_b === 1'b0, "R10 pg after reset", int'(pg_a | pg_b), 0);
    check(pci_rst_n === 1'b0 && cpu_rst_n === 1'b0, "R10 resets after reset",
          int'(pci_rst_n | cpu_rst_n), 0);
    check(rail_ready === 1'b1, "R10 ready high", int'(rail_ready), 1);

    // R10: codes without valid are ignored
    en_a = 1'b1;
    sample(3000, 0, 0, 1'b0);
    expect_at(702 * DIV, 0, 1'b0, "R10 no valid no pg_a");
    drain();

    // R1: exactly 2943 is not good
    sample(2943, 0, 0, 1'b1);
    expect_at(702 * DIV, 0, 1'b0, "R1 boundary 2943");
    drain();

    // R1: good rail gives pg_a after 700 ticks
    sample(3000, 0, 0, 1'b1);
    expect_rise(0, 700, "R1 pg_a delay");
    drain();

    // R2: between thresholds holds good; R3: below falls at once
    sample(2793, 0, 0, 1'b1);
    expect_at(20, 0, 1'b1, "R2 hold good at 2793");
    drain();
    sample(2792, 0, 0, 1'b1);
    expect_at(1, 0, 1'b0, "R3 bad drops pg_a");
    drain();
    sample(2943, 0, 0, 1'b1);
    expect_at(702 * DIV, 0, 1'b0, "R2 hold bad at 2943");
    drain();

    // R3: bad mid-delay cancels; full delay restarts
    sample(3000, 0, 0, 1'b1);
    repeat (400) @(negedge clk);
    sample(2700, 0, 0, 1'b1);
    expect_at(2, 0, 1'b0, "R3 cancel");
    sample(3000, 0, 0, 1'b1);
    expect_rise(0, 700, "R3 restart full delay");
    drain();

    // R4: enable drop clears; re-enable needs new sample
    en_a = 1'b0;
    expect_at(2, 0, 1'b0, "R4 en_a drop");
    drain();
    en_a = 1'b1;
    expect_at(702 * DIV, 0, 1'b0, "R4 state cleared");
    drain();
    sample(3000, 0, 0, 1'b1);
    expect_rise(0, 700, "R4 new sample after enable");
    drain();

    // R5: one B enable is not enough
    en_b5 = 1'b1;
    sample(3000, 4500, 3000, 1'b1);
    expect_at(892 * DIV, 1, 1'b0, "R5 single enable");
    drain();

    // R6: 5 V boundary 4461 is not good
    en_b3 = 1'b1;
    sample(3000, 4461, 3000, 1'b1);
    expect_at(892 * DIV, 1, 1'b0, "R6 boundary 4461");
    drain();

    // R8 long delay with pg_a high; R6 thresholds met
    sample(3000, 4462, 3000, 1'b1);
    expect_rise(1, 890, "R8 long delay");
    drain();
    repeat (40) @(negedge clk);
    check(pci_rise - pgb_rise == 2 * DIV, "R9 pci delay", int'(pci_rise - pgb_rise), 2 * DIV);
    check(cpu_rise - pci_rise == 2 * DIV, "R9 cpu delay", int'(cpu_rise - pci_rise), 2 * DIV);

    // R7: short dip ignored
    sample(3000, 4462, 2700, 1'b1);
    repeat (50 * DIV) @(negedge clk);
    sample(3000, 4462, 3000, 1'b1);
    expect_at(DIV, 1, 1'b1, "R7 short dip ignored");
    drain();

    // R7: persistent bad drops after 95 ticks; R9 resets follow
    sample(3000, 4300, 3000, 1'b1);
    expect_at(94 * DIV - 2, 1, 1'b1, "R7 held before 95 ticks");
    expect_at(96 * DIV + 4, 1, 1'b0, "R7 dropped after 95 ticks");
    expect_at(96 * DIV + 6, 2, 1'b0, "R9 pci reasserted");
    expect_at(96 * DIV + 6, 3, 1'b0, "R9 cpu reasserted");
    drain();

    // R8 short delay with pg_a low
    en_a = 1'b0;
    sample(0, 4500, 3000, 1'b1);
    expect_rise(1, 200, "R8 short delay");
    drain();

    // R8 length fixed at start: start long, then drop pg_a
    en_a = 1'b1;
    sample(3000, 4300, 3000, 1'b1);
    expect_rise(0, 700, "R1 pg_a for R8 case");
    drain();
    check(pg_b === 1'b0, "R7 pg_b dropped for R8 case", int'(pg_b), 0);
    sample(3000, 4500, 3000, 1'b1);
    expect_at(403, 0, 1'b0, "R4 pg_a drop in R8 case");
    expect_at(230 * DIV, 1, 1'b0, "R8 not shortened");
    expect_rise(1, 890, "R8 fixed long delay");
    repeat (400) @(negedge clk);
    en_a = 1'b0;
    drain();

    // R5: B enable drop clears pg_b at once; R9 resets follow
    repeat (40) @(negedge clk);
    en_b3 = 1'b0;
    expect_at(2, 1, 1'b0, "R5 enable drop clears pg_b");
    expect_at(3, 2, 1'b0, "R9 pci after enable drop");
    expect_at(3, 3, 1'b0, "R9 cpu after enable drop");
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule